// File: doc/BRIEF.md
# Block Output Completion Detector

This block follows one in-flight atomic instruction block and reports when that block has produced every output it owes. A block always emits the same set of outputs whichever predicated path it takes: its stores, its register writes and exactly one branch. Completion can therefore be found by crossing off expected outputs as they arrive. The block does not count instructions.

A load strobe starts a block. The strobe carries two things: a store mask, with one bit for each load/store identifier, and the block's write-header entries. The valid flags of those entries give the register-write slots the block must fill, and the block always owes one branch. Three event ports then report finished stores (by identifier), finished register writes (by slot) and the branch. Once nothing is outstanding, a one-cycle done pulse is raised. An event the block did not expect sets a protocol-error pulse. A flush input drops the block at any time.

Top module: `cmpl_detect`

## Requirements
- R1: After reset `done_o` and `proto_err_o` are low and no block is tracked, so any store, write or branch event raises `proto_err_o` in the cycle after it.
- R2: On `blk_load_i`, bit i of `st_mask_i` marks load/store identifier i as an outstanding store. Each store event clears the bit of its `st_lsid_i`.
- R3: Write-header entry i occupies bits [6i+5:6i] of `wr_hdr_i`. Bit 5 of an entry is its valid flag and bits 4..0 are a register index. Only a set valid flag makes slot i an outstanding write, and the index bits have no effect.
- R4: `done_o` is high for exactly one cycle. It rises on the clock edge after the edge that accepts the last outstanding store, write or branch.
- R5: After the done pulse, `done_o` stays low until the next `blk_load_i`, and any event in that interval raises `proto_err_o`.
- R6: A store or write event whose bit is not outstanding raises `proto_err_o` for one cycle and changes no tracking state, so the block still completes exactly when its real outputs arrive.
- R7: The first branch event of a block is accepted. A second branch event in the same block raises `proto_err_o`.
- R8: `flush_i` clears all tracking state and returns to idle, including in the cycle in which completion would have fired. Events in a flush cycle are ignored and raise no error, and no done pulse follows.
- R9: `blk_load_i` takes priority over events in the same cycle. Those events are ignored without error. A load during a running block restarts tracking from the new mask and header, and `flush_i` beats `blk_load_i`.
- R10: A block with an empty store mask and no valid write entries completes on its branch alone.
- R11: Events on the three ports in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_load_i | input | 1 | Start tracking a new block |
| st_mask_i | input | 32 | Store mask, one bit per load/store identifier |
| wr_hdr_i | input | 192 | 32 write-header entries of 6 bits |
| flush_i | input | 1 | Synchronous flush of the tracked block |
| st_vld_i | input | 1 | Store completion event |
| st_lsid_i | input | 5 | Identifier of the completed store |
| wr_vld_i | input | 1 | Register-write completion event |
| wr_slot_i | input | 5 | Write slot of the completed write |
| br_vld_i | input | 1 | Branch completion event |
| done_o | output | 1 | One-cycle block-completed pulse |
| proto_err_o | output | 1 | One-cycle unexpected-event pulse |

## Verification
A pending bit that is wrongly left set or wrongly cleared shows at the ports in one of two ways. Either the done pulse is missing or comes a cycle early or late, or an error pulse appears one cycle after an event that should be legal (or fails to appear after one that should not). The directed scenarios therefore sample `done_o` on the exact cycle after the last expected output and on the cycles around it. Each duplicate or stray event is followed by the real events, which exposes any state the stray event may have altered. Flush and load are made to collide with events and with the completion cycle, so that a wrong priority order shows as a spurious error or done pulse within one cycle.

// File: rtl/cmpl_pkg.sv
// Shared constants for the block completion detector.
// Assumes a 32-entry store identifier space and 32 write-header slots.
package cmpl_pkg;
    localparam int LSID_N    = 32;
    localparam int WSLOT_N   = 32;
    localparam int WENT_W    = 6;
    localparam int WENT_VLD  = 5;
endpackage

// File: rtl/cmpl_hdr_decode.sv
// Extracts the valid flag of each write-header entry into a slot vector.
// Assumes entries packed back to back, entry i at bits [i*ENT_W +: ENT_W].
module cmpl_hdr_decode #(
    parameter int SLOTS = 32,
    parameter int ENT_W = 6,
    parameter int VLD_B = 5
) (
    input  logic [SLOTS*ENT_W-1:0] hdr_i,
    output logic [SLOTS-1:0]       valid_o
);
    localparam int IDX_W = ENT_W - 1;

    logic [SLOTS*IDX_W-1:0] unused_idx_bits;
    logic                   unused_idx;

    // Split each entry into its valid flag and its (unused here) index bits.
    for (genvar i = 0; i < SLOTS; i++) begin : g_ent
        assign valid_o[i] = hdr_i[i*ENT_W + VLD_B];
        assign unused_idx_bits[i*IDX_W +: IDX_W] = hdr_i[i*ENT_W +: IDX_W];
    end

    assign unused_idx = ^unused_idx_bits;
endmodule

// File: rtl/cmpl_slot_track.sv
// Pending-bit vector for one class of outputs (stores or register writes).
// Loaded with the expected set, cleared bit by bit as events arrive.
// Assumes at most one event per cycle on its port; flush and load mask events.
module cmpl_slot_track #(
    parameter int N = 32,
    localparam int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush_i,
    input  logic           done_i,
    input  logic           load_i,
    input  logic [N-1:0]   init_i,
    input  logic           ev_vld_i,
    input  logic [IDW-1:0] ev_id_i,
    output logic           empty_o,
    output logic           bad_o
);
    logic [N-1:0] pend_q;
    logic         ev_live;

    // An event counts only outside flush and load cycles.
    assign ev_live = ev_vld_i && !flush_i && !load_i;
    // An event for a bit that is not outstanding is a protocol error.
    assign bad_o   = ev_live && !pend_q[ev_id_i];
    assign empty_o = (pend_q == '0);

    // Pending vector update: clear, load, or retire one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i || done_i) begin
            pend_q <= '0;
        end else if (load_i) begin
            pend_q <= init_i;
        end else if (ev_live && pend_q[ev_id_i]) begin
            pend_q[ev_id_i] <= 1'b0;
        end
    end

    // R2: an accepted event retires exactly its own bit.
    p_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld_i && !bad_o && !flush_i && !done_i && !load_i)
        |=> !pend_q[$past(ev_id_i)]);

    // R6: a rejected event leaves the vector untouched.
    p_bad_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_o && !flush_i && !done_i && !load_i) |=> $stable(pend_q));
endmodule

// File: rtl/cmpl_branch_track.sv
// Tracks the single branch a block must emit.
// Assumes the caller reports whether a block is active.
module cmpl_branch_track (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic done_i,
    input  logic load_i,
    input  logic active_i,
    input  logic br_vld_i,
    output logic seen_o,
    output logic bad_o
);
    logic seen_q;
    logic br_live;

    assign br_live = br_vld_i && !flush_i && !load_i;
    // A branch with none expected (idle, or already seen) is an error.
    assign bad_o   = br_live && (seen_q || !active_i);
    assign seen_o  = seen_q;

    // Branch-received flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i || done_i || load_i) begin
            seen_q <= 1'b0;
        end else if (br_live && !seen_q && active_i) begin
            seen_q <= 1'b1;
        end
    end

    // R7: once seen, the flag holds until cleared by flush, load or done.
    p_seen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !flush_i && !done_i && !load_i) |=> seen_q);
endmodule

// File: rtl/cmpl_detect.sv
// Block completion detector top. Loads expected stores, writes and one
// branch at block start, crosses them off as events arrive and pulses
// done_o one cycle after the last one. Assumes one block in flight.
module cmpl_detect
    import cmpl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blk_load_i,
    input  logic [LSID_N-1:0]         st_mask_i,
    input  logic [WSLOT_N*WENT_W-1:0] wr_hdr_i,
    input  logic                      flush_i,
    input  logic                      st_vld_i,
    input  logic [$clog2(LSID_N)-1:0] st_lsid_i,
    input  logic                      wr_vld_i,
    input  logic [$clog2(WSLOT_N)-1:0] wr_slot_i,
    input  logic                      br_vld_i,
    output logic                      done_o,
    output logic                      proto_err_o
);
    logic [WSLOT_N-1:0] wr_init;
    logic st_empty, wr_empty, br_seen;
    logic st_bad, wr_bad, br_bad;
    logic load_eff, fire;
    logic active_q, done_q, err_q;

    assign load_eff = blk_load_i && !flush_i;
    // Completion: running, nothing outstanding, branch in, no override.
    assign fire = active_q && st_empty && wr_empty && br_seen
                  && !flush_i && !blk_load_i;

    cmpl_hdr_decode #(.SLOTS(WSLOT_N), .ENT_W(WENT_W), .VLD_B(WENT_VLD)) u_dec (
        .hdr_i   (wr_hdr_i),
        .valid_o (wr_init)
    );

    cmpl_slot_track #(.N(LSID_N)) u_st (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .done_i(fire),
        .load_i(load_eff), .init_i(st_mask_i),
        .ev_vld_i(st_vld_i), .ev_id_i(st_lsid_i),
        .empty_o(st_empty), .bad_o(st_bad)
    );

    cmpl_slot_track #(.N(WSLOT_N)) u_wr (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .done_i(fire),
        .load_i(load_eff), .init_i(wr_init),
        .ev_vld_i(wr_vld_i), .ev_id_i(wr_slot_i),
        .empty_o(wr_empty), .bad_o(wr_bad)
    );

    cmpl_branch_track u_br (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .done_i(fire),
        .load_i(load_eff), .active_i(active_q), .br_vld_i(br_vld_i),
        .seen_o(br_seen), .bad_o(br_bad)
    );

    // Block-in-flight flag: set by load, dropped by flush or completion.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            active_q <= 1'b0;
        end else if (blk_load_i) begin
            active_q <= 1'b1;
        end else if (fire) begin
            active_q <= 1'b0;
        end
    end

    // Registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= fire;
            err_q  <= st_bad || wr_bad || br_bad;
        end
    end

    assign done_o      = done_q;
    assign proto_err_o = err_q;

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: while done is high nothing is left outstanding.
    p_done_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (st_empty && wr_empty));

    // R8: a flush cycle is followed by neither done nor error.
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!done_o && !proto_err_o));

    // R9: a load cycle never produces an error.
    p_load_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_load_i |=> !proto_err_o);
endmodule

// File: tb/sim_cmpl_detect.sv
module sim_cmpl_detect;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         blk_load_i;
    logic [31:0]  st_mask_i;
    logic [191:0] wr_hdr_i;
    logic         flush_i, st_vld_i, wr_vld_i, br_vld_i;
    logic [4:0]   st_lsid_i, wr_slot_i;
    logic         done_o, proto_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpl_detect u0 (
        .clk(clk), .rst_n(rst_n), .blk_load_i(blk_load_i),
        .st_mask_i(st_mask_i), .wr_hdr_i(wr_hdr_i), .flush_i(flush_i),
        .st_vld_i(st_vld_i), .st_lsid_i(st_lsid_i),
        .wr_vld_i(wr_vld_i), .wr_slot_i(wr_slot_i), .br_vld_i(br_vld_i),
        .done_o(done_o), .proto_err_o(proto_err_o)
    );

    // Header builder: valid flag at bit 5 of entry i; invalid entries get junk index bits.
    function automatic logic [191:0] mk_hdr(input logic [31:0] vld);
        logic [191:0] h = '0;
        for (int i = 0; i < 32; i++)
            h[i*6 +: 6] = vld[i] ? {1'b1, 5'(i)} : 6'h1F;
        return h;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        blk_load_i = 0; flush_i = 0; st_vld_i = 0; wr_vld_i = 0; br_vld_i = 0;
        st_lsid_i = 0; wr_slot_i = 0; st_mask_i = 0; wr_hdr_i = mk_hdr(32'h0);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Drive one cycle of events, then return inputs to idle.
    task automatic ev(input logic s, input logic [4:0] sid, input logic w,
                      input logic [4:0] wid, input logic b, input logic fl);
        st_vld_i = s; st_lsid_i = sid; wr_vld_i = w; wr_slot_i = wid;
        br_vld_i = b; flush_i = fl;
        step();
        idle_in();
    endtask

    task automatic load(input logic [31:0] m, input logic [31:0] wv);
        blk_load_i = 1; st_mask_i = m; wr_hdr_i = mk_hdr(wv);
        step();
        idle_in();
    endtask

    task automatic t_reset();
        chk("R1", "done after reset", done_o, 1'b0);
        chk("R1", "err after reset", proto_err_o, 1'b0);
        ev(1, 5'd3, 0, 0, 0, 0);
        chk("R1", "store while idle err", proto_err_o, 1'b1);
        ev(0, 0, 0, 0, 1, 0);
        chk("R1", "branch while idle err", proto_err_o, 1'b1);
    endtask

    task automatic t_basic();
        load(32'h0002_0008, 32'h8000_0001);
        ev(1, 5'd3, 0, 0, 0, 0);
        chk("R2", "store 3 legal", proto_err_o, 1'b0);
        ev(0, 0, 1, 5'd0, 0, 0);
        chk("R3", "write 0 legal", proto_err_o, 1'b0);
        ev(0, 0, 0, 0, 1, 0);
        chk("R7", "first branch legal", proto_err_o, 1'b0);
        ev(1, 5'd17, 0, 0, 0, 0);
        chk("R2", "store 17 legal", proto_err_o, 1'b0);
        chk("R4", "no done while write 31 owed", done_o, 1'b0);
        ev(0, 0, 1, 5'd31, 0, 0);
        chk("R4", "done not yet on last edge", done_o, 1'b0);
        step();
        chk("R4", "done one cycle after last", done_o, 1'b1);
        step();
        chk("R4", "done falls", done_o, 1'b0);
    endtask

    task automatic t_after_done();
        step(); step();
        chk("R5", "done stays low", done_o, 1'b0);
        ev(0, 0, 1, 5'd31, 0, 0);
        chk("R5", "event after done err", proto_err_o, 1'b1);
        step();
        chk("R5", "no done after stray", done_o, 1'b0);
    endtask

    task automatic t_dup();
        load(32'h0000_0020, 32'h0);
        ev(1, 5'd5, 0, 0, 0, 0);
        chk("R6", "store 5 legal", proto_err_o, 1'b0);
        ev(1, 5'd5, 0, 0, 0, 0);
        chk("R6", "duplicate store err", proto_err_o, 1'b1);
        ev(1, 5'd6, 0, 0, 0, 0);
        chk("R6", "unmasked store err", proto_err_o, 1'b1);
        ev(0, 0, 1, 5'd2, 0, 0);
        chk("R3", "invalid header slot err", proto_err_o, 1'b1);
        ev(0, 0, 0, 0, 1, 0);
        chk("R6", "branch legal after errors", proto_err_o, 1'b0);
        chk("R6", "no early done", done_o, 1'b0);
        step();
        chk("R6", "completes after stray events", done_o, 1'b1);
        step();
    endtask

    task automatic t_branch2();
        load(32'h0000_0001, 32'h0);
        ev(0, 0, 0, 0, 1, 0);
        chk("R7", "first branch ok", proto_err_o, 1'b0);
        ev(0, 0, 0, 0, 1, 0);
        chk("R7", "second branch err", proto_err_o, 1'b1);
        ev(1, 5'd0, 0, 0, 0, 0);
        chk("R7", "store 0 ok", proto_err_o, 1'b0);
        step();
        chk("R7", "completes once", done_o, 1'b1);
        step();
    endtask

    task automatic t_flush();
        load(32'h0000_0002, 32'h0);
        ev(0, 0, 0, 0, 1, 0);
        ev(1, 5'd1, 0, 0, 0, 1);
        chk("R8", "event in flush no err", proto_err_o, 1'b0);
        step();
        chk("R8", "no done after flush", done_o, 1'b0);
        ev(1, 5'd1, 0, 0, 0, 0);
        chk("R8", "idle after flush err", proto_err_o, 1'b1);
        load(32'h0, 32'h0);
        ev(0, 0, 0, 0, 1, 0);
        ev(0, 0, 0, 0, 0, 1);
        chk("R8", "flush in fire cycle no done", done_o, 1'b0);
        step();
        chk("R8", "done stays suppressed", done_o, 1'b0);
    endtask

    task automatic t_load_prio();
        load(32'h0000_0004, 32'h0);
        blk_load_i = 1; st_mask_i = 32'h0000_0010; wr_hdr_i = mk_hdr(32'h0);
        st_vld_i = 1; st_lsid_i = 5'd2; br_vld_i = 1;
        step(); idle_in();
        chk("R9", "events in load cycle no err", proto_err_o, 1'b0);
        ev(1, 5'd2, 0, 0, 0, 0);
        chk("R9", "old mask gone", proto_err_o, 1'b1);
        ev(1, 5'd4, 0, 0, 0, 0);
        chk("R9", "new mask bit legal", proto_err_o, 1'b0);
        ev(0, 0, 0, 0, 1, 0);
        chk("R9", "branch in load cycle was ignored", proto_err_o, 1'b0);
        step();
        chk("R9", "restarted block completes", done_o, 1'b1);
        step();
        blk_load_i = 1; flush_i = 1; step(); idle_in();
        ev(0, 0, 0, 0, 1, 0);
        chk("R9", "flush beats load", proto_err_o, 1'b1);
    endtask

    task automatic t_empty();
        load(32'h0, 32'h0);
        step();
        chk("R10", "no done before branch", done_o, 1'b0);
        ev(0, 0, 0, 0, 1, 0);
        step();
        chk("R10", "branch alone completes", done_o, 1'b1);
        step();
    endtask

    task automatic t_simul();
        load(32'h0000_0080, 32'h0000_0200);
        ev(1, 5'd7, 1, 5'd9, 1, 0);
        chk("R11", "joint events no err", proto_err_o, 1'b0);
        step();
        chk("R11", "joint events complete", done_o, 1'b1);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_basic();
        t_after_done();
        t_dup();
        t_branch2();
        t_flush();
        t_load_prio();
        t_empty();
        t_simul();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule